// File: doc/BRIEF.md
# Write-Once Coherence Line Controller

This block tracks the coherence state of a single cache line under a four-state write-once snooping protocol. A line is Invalid, Valid (clean, possibly shared), Reserved (written once, with memory still up to date), or Dirty (modified, with memory stale). The first processor write to a clean line goes through to memory as a write-once bus transaction. Only a second write makes the line Dirty, and that write needs no bus traffic.

In each cycle the block takes one local processor operation and one snooped bus operation. It raises the bus request that the protocol calls for in the same cycle. The line state it reports is registered and takes its new value at the next clock edge. If a snoop and a local request arrive together, the snoop is applied first. The local request is then judged against the state the snoop left behind. Data storage, memory timing and bus arbitration belong to the surrounding cache.

Top module: `wo_line_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the line state is Invalid (00) and no bus request is raised. The state encoding is Invalid 00, Valid 01, Reserved 10, Dirty 11.
- R2: A local read (pr_op 01) on an Invalid line raises bus_rd in the same cycle, and the state becomes Valid at the next edge.
- R3: A local write (pr_op 10) on an Invalid line raises bus_rdx in the same cycle, and the state becomes Dirty.
- R4: A local write on a Valid line raises bus_wronce in the same cycle, and the state becomes Reserved.
- R5: A local write on a Reserved or Dirty line raises no bus request, and the state becomes Dirty.
- R6: A local read on a Valid, Reserved or Dirty line raises no bus request and leaves the state unchanged.
- R7: On a Dirty line, a snooped read (snp_op 01) raises bus_wb and moves the line to Valid. A snooped read-exclusive (snp_op 10) raises bus_wb and moves the line to Invalid. A snooped write-once (snp_op 11) changes nothing.
- R8: A snooped read-exclusive or write-once moves a Valid or Reserved line to Invalid without a write-back. A snooped read moves Reserved to Valid and leaves Valid as it is. An Invalid line ignores all snoops.
- R9: When a snoop and a local request arrive in the same cycle, the snoop takes effect first. The local request's bus request and final state then follow from the post-snoop state, and both the write-back and the local request may be raised together.
- R10: pr_op 11 and pr_op 00 are idle codes. With no snoop present, an idle code raises no request and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pr_op | input | 2 | Local operation: 00 idle, 01 read, 10 write, 11 idle |
| snp_op | input | 2 | Snooped operation: 00 none, 01 read, 10 read-exclusive, 11 write-once |
| bus_rd | output | 1 | Request a bus read (same cycle) |
| bus_rdx | output | 1 | Request a bus read-exclusive (same cycle) |
| bus_wronce | output | 1 | Request a write-once write-through (same cycle) |
| bus_wb | output | 1 | Request a write-back of the line (same cycle) |
| line_state | output | 2 | Registered line state |

## Verification
The four bus requests are combinational, so they are due in the same cycle as the operation that causes them. The bench drives its inputs just after the falling edge and samples the requests a nanosecond later, well before the next rising edge. The line state passes through one register, so a new value is due one rising edge after the stimulus. The bench therefore compares line_state at the following sample point, against a reference model that advances once per clock. A table of operation pairs walks every transition, including same-cycle snoop-plus-local pairs, and every sample compares all five outputs.

// File: rtl/wo_line_pkg.sv
package wo_line_pkg;
  localparam int STATE_W = 2;
  localparam int OP_W    = 2;

  typedef enum logic [STATE_W-1:0] {
    LS_INV = 2'b00,
    LS_VAL = 2'b01,
    LS_RES = 2'b10,
    LS_DRT = 2'b11
  } line_state_t;

  typedef enum logic [OP_W-1:0] {
    PR_IDLE  = 2'b00,
    PR_READ  = 2'b01,
    PR_WRITE = 2'b10,
    PR_RSVD  = 2'b11
  } pr_op_t;

  typedef enum logic [OP_W-1:0] {
    SN_NONE  = 2'b00,
    SN_READ  = 2'b01,
    SN_RDX   = 2'b10,
    SN_WONCE = 2'b11
  } snp_op_t;
endpackage

// File: rtl/wo_snoop_stage.sv
module wo_snoop_stage
  import wo_line_pkg::*;
(
  input  line_state_t cur_state,
  input  snp_op_t     snp,
  output line_state_t mid_state,
  output logic        wb_req
);
  always_comb begin
    mid_state = cur_state;
    wb_req    = 1'b0;
    unique case (snp)
      SN_READ: begin
        if (cur_state == LS_DRT) begin
          wb_req    = 1'b1;
          mid_state = LS_VAL;
        end else if (cur_state == LS_RES) begin
          mid_state = LS_VAL;
        end
      end
      SN_RDX: begin
        if (cur_state == LS_DRT) begin
          wb_req    = 1'b1;
          mid_state = LS_INV;
        end else if (cur_state != LS_INV) begin
          mid_state = LS_INV;
        end
      end
      SN_WONCE: begin
        if (cur_state == LS_VAL || cur_state == LS_RES) begin
          mid_state = LS_INV;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wo_local_stage.sv
module wo_local_stage
  import wo_line_pkg::*;
(
  input  line_state_t mid_state,
  input  pr_op_t      op,
  output line_state_t nxt_state,
  output logic        rd_req,
  output logic        rdx_req,
  output logic        wonce_req
);
  always_comb begin
    nxt_state = mid_state;
    rd_req    = 1'b0;
    rdx_req   = 1'b0;
    wonce_req = 1'b0;
    unique case (op)
      PR_READ: begin
        if (mid_state == LS_INV) begin
          rd_req    = 1'b1;
          nxt_state = LS_VAL;
        end
      end
      PR_WRITE: begin
        unique case (mid_state)
          LS_INV: begin
            rdx_req   = 1'b1;
            nxt_state = LS_DRT;
          end
          LS_VAL: begin
            wonce_req = 1'b1;
            nxt_state = LS_RES;
          end
          default: nxt_state = LS_DRT;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wo_state_reg.sv
module wo_state_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/wo_line_ctrl.sv
module wo_line_ctrl
  import wo_line_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OP_W-1:0]    pr_op,
  input  logic [OP_W-1:0]    snp_op,
  output logic               bus_rd,
  output logic               bus_rdx,
  output logic               bus_wronce,
  output logic               bus_wb,
  output logic [STATE_W-1:0] line_state
);
  line_state_t        cur_state;
  line_state_t        mid_state;
  line_state_t        nxt_state;
  logic [STATE_W-1:0] state_q;
  logic               state_en;

  assign cur_state = line_state_t'(state_q);

  wo_snoop_stage i_snoop (
    .cur_state (cur_state),
    .snp       (snp_op_t'(snp_op)),
    .mid_state (mid_state),
    .wb_req    (bus_wb)
  );

  wo_local_stage i_local (
    .mid_state (mid_state),
    .op        (pr_op_t'(pr_op)),
    .nxt_state (nxt_state),
    .rd_req    (bus_rd),
    .rdx_req   (bus_rdx),
    .wonce_req (bus_wronce)
  );

  assign state_en = (nxt_state != cur_state);

  wo_state_reg #(.W(STATE_W)) i_state (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state_en),
    .d     (nxt_state),
    .q     (state_q)
  );

  assign line_state = state_q;
endmodule

// File: rtl/wo_line_ctrl_chk.sv
module wo_line_ctrl_chk
  import wo_line_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [OP_W-1:0]    pr_op,
  input logic [OP_W-1:0]    snp_op,
  input logic               bus_rd,
  input logic               bus_rdx,
  input logic               bus_wronce,
  input logic               bus_wb,
  input logic [STATE_W-1:0] line_state
);
  p_one_local_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_rdx, bus_wronce}));

  p_wb_needs_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wb |-> line_state == LS_DRT);

  p_rd_to_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> line_state == LS_VAL);

  p_rdx_to_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdx |=> line_state == LS_DRT);

  p_wonce_to_res_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wronce |=> line_state == LS_RES);

  p_res_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_RES && pr_op == PR_WRITE && snp_op == SN_NONE)
      |-> !(bus_rd || bus_rdx || bus_wronce || bus_wb));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pr_op == PR_IDLE || pr_op == PR_RSVD) && snp_op == SN_NONE)
      |=> $stable(line_state));
endmodule

bind wo_line_ctrl wo_line_ctrl_chk i_chk (.*);

// File: tb/test_wo_line_ctrl.sv
module test_wo_line_ctrl;
  logic       clk;
  logic       rst_n;
  logic [1:0] pr_op;
  logic [1:0] snp_op;
  logic       bus_rd, bus_rdx, bus_wronce, bus_wb;
  logic [1:0] line_state;

  int n_checks = 0;
  int n_fail   = 0;
  int m_state  = 0;
  bit done     = 0;

  wo_line_ctrl i_wo_line_ctrl (
    .clk(clk), .rst_n(rst_n), .pr_op(pr_op), .snp_op(snp_op),
    .bus_rd(bus_rd), .bus_rdx(bus_rdx), .bus_wronce(bus_wronce),
    .bus_wb(bus_wb), .line_state(line_state)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference: states 0 I, 1 V, 2 R, 3 D.
  function automatic void ref_model(input int s, input int p, input int n,
                                    output int ns, output bit [3:0] req);
    int t;
    t = s;
    req = 4'b0000; // {rd, rdx, wonce, wb}
    if (n == 1) begin
      if (s == 3) begin req[0] = 1'b1; t = 1; end
      else if (s == 2) t = 1;
    end else if (n == 2) begin
      if (s == 3) req[0] = 1'b1;
      t = 0;
    end else if (n == 3) begin
      if (s == 1 || s == 2) t = 0;
    end
    ns = t;
    if (p == 1 && t == 0) begin
      req[3] = 1'b1; ns = 1;
    end else if (p == 2) begin
      if (t == 0) begin req[2] = 1'b1; ns = 3; end
      else if (t == 1) begin req[1] = 1'b1; ns = 2; end
      else ns = 3;
    end
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int p, input int n, input string req);
    int ns;
    bit [3:0] exp_req;
    @(negedge clk);
    pr_op  = p[1:0];
    snp_op = n[1:0];
    #1;
    ref_model(m_state, p, n, ns, exp_req);
    check(req, "line_state", int'(line_state), m_state);
    check(req, "bus {rd,rdx,wronce,wb}",
          int'({bus_rd, bus_rdx, bus_wronce, bus_wb}), int'(exp_req));
    m_state = ns;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    rst_n  = 1'b0;
    pr_op  = 2'b00;
    snp_op = 2'b00;
    #2;
    check("R1", "reset state", int'(line_state), 0);
    check("R1", "reset requests", int'({bus_rd, bus_rdx, bus_wronce, bus_wb}), 0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 / R10 / R8: idle and ignored inputs on Invalid
    step(0, 0, "R1");
    step(3, 0, "R10");
    step(0, 1, "R8");
    step(0, 2, "R8");
    step(0, 3, "R8");
    // R2, R6, R4
    step(1, 0, "R2");
    step(1, 0, "R6");
    step(0, 1, "R8");
    step(2, 0, "R4");
    step(1, 0, "R6");
    step(3, 0, "R10");
    step(0, 1, "R8");
    step(2, 0, "R4");
    step(0, 2, "R8");
    step(1, 0, "R2");
    step(2, 0, "R4");
    step(0, 3, "R8");
    // R3, R5, R7
    step(2, 0, "R3");
    step(1, 0, "R6");
    step(2, 0, "R5");
    step(0, 3, "R7");
    step(0, 1, "R7");
    step(2, 0, "R4");
    step(2, 0, "R5");
    step(0, 0, "R5");
    step(0, 2, "R7");
    step(1, 0, "R2");
    step(0, 2, "R8");
    step(1, 0, "R2");
    step(0, 3, "R8");
    // R9: same-cycle snoop and local request
    step(2, 0, "R3");
    step(2, 2, "R9");
    step(1, 1, "R9");
    step(2, 3, "R9");
    step(2, 1, "R9");
    step(1, 2, "R9");
    step(3, 2, "R10");
    step(0, 0, "R10");
    done = 1'b1;
    summary();
  end
endmodule